// File: doc/BRIEF.md
# Converter Serial Readout Controller

This block sits on the host side of a multiplexed delta-sigma converter and runs its four-wire serial port: an active-low select, a serial clock the host drives, a host-to-converter data line, and a converter-to-host data line. A request starts a readout. The controller keeps select high for a short guard interval. It then pulls select low with the clock held low, so the converter latches host-driven clock mode and wakes. While select is low, the converter drives its data line high until a result is ready.

The controller samples that status line once per clock half-period. When it sees a low level, it clocks a frame of `FRAME_BITS` bits. It captures the converter's bits on rising clock edges. On the same frame it sends the next input-multiplexer address, most significant bit first, on falling edges. At the end of the frame it raises select, which starts the next conversion, and presents the captured word with a one-cycle strobe.

An abort request ends a poll or a frame at once: select goes high and nothing is reported. A poll that never sees the ready level within `POLL_LIMIT` samples ends the attempt and raises a sticky error flag. The clock half-period is `clk_div` system cycles, and the value must be nonzero.

Top module: `adc_readout_ctrl`

## Requirements
- R1: After reset, select is high, the serial clock is low, the data-to-converter line is low, the strobe is low and the error flag is low.
- R2: A start request seen while idle keeps select high for 4 clock half-periods and then drives it low. A start request seen while a readout is in progress is ignored and does not change the address that is sent.
- R3: While select is low and the controller is polling, the serial clock stays low. The converter data line is sampled once per half-period, and the first low sample begins the frame.
- R4: A frame has exactly 2*FRAME_BITS half-periods. The clock rises on the odd ones, and the converter's bit is captured at each rise, so the first captured bit becomes the word's most significant bit.
- R5: On the data-to-converter line the frame carries the latched address in its top ADDR_BITS positions, most significant bit first, with zeros after it. The line is set when the frame begins and changes only as the clock falls, and it is low whenever select is high.
- R6: On the last falling edge of the frame, select returns high, the strobe is high for exactly one cycle with the captured word on `result`, and `result` then holds that word.
- R7: An abort request during polling or a frame drives select high and the clock low on the next cycle. No strobe follows, and `result` keeps its previous value.
- R8: After POLL_LIMIT consecutive high status samples, select returns high and the error flag is set. The flag stays set until the next accepted start request clears it.
- R9: Every half-period, and every guard and poll interval, lasts exactly `clk_div` system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one readout; accepted only while idle |
| mux_addr | input | ADDR_BITS | Next multiplexer address, latched on an accepted start |
| abort_req | input | 1 | End the current poll or frame at once |
| clk_div | input | DIV_W | System cycles per serial-clock half-period (nonzero) |
| spi_sdo | input | 1 | Converter status / data output |
| spi_cs_n | output | 1 | Active-low select to the converter |
| spi_sck | output | 1 | Serial clock driven to the converter |
| spi_sdi | output | 1 | Address bits to the converter |
| result | output | FRAME_BITS | Last captured frame |
| result_valid | output | 1 | One-cycle strobe when `result` is updated |
| timeout_err | output | 1 | Sticky status-poll timeout flag |

## Verification
The bench focuses on timing edges. It runs several divider values, including 1, where a mistake of one half-period in the guard, the poll or the frame length shows up at once as a select or clock edge on the wrong cycle. A behavioural converter model records the address bits at each rising clock edge. This exposes an address that was sent in reversed order, taken one edge late, or replaced by a start request issued in mid-poll.

An abort issued in the middle of a frame catches a design that still raises the strobe or overwrites the result. A poll that never sees the ready level checks two failure modes: a design that never gives up, and a design whose error flag does not clear on the next accepted start.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GAP   = 2'd1,
        ST_POLL  = 2'd2,
        ST_SHIFT = 2'd3
    } rd_state_e;

endpackage

// File: rtl/rdc_tick_gen.sv
module rdc_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    // a tick closes every half-period of div system cycles
    always_comb begin
        tick  = en && (cnt_q == div - DIV_W'(1));
        cnt_d = (!en || tick) ? '0 : cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/rdc_shifter.sv
module rdc_shifter #(
    parameter int FRAME_BITS = 32,
    parameter int ADDR_BITS  = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [ADDR_BITS-1:0]  addr,
    input  logic                  advance,
    input  logic                  cap_en,
    input  logic                  cap_bit,
    output logic                  tx_msb,
    output logic                  tx_next,
    output logic [FRAME_BITS-1:0] rx_word
);

    localparam int PAD = FRAME_BITS - ADDR_BITS;

    typedef struct packed {
        logic [FRAME_BITS-1:0] tx;
        logic [FRAME_BITS-1:0] rx;
    } shreg_s;

    shreg_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.tx = {addr, {PAD{1'b0}}};
            r_d.rx = '0;
        end else begin
            if (advance) r_d.tx = {r_q.tx[FRAME_BITS-2:0], 1'b0};
            if (cap_en)  r_d.rx = {r_q.rx[FRAME_BITS-2:0], cap_bit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tx_msb  = r_q.tx[FRAME_BITS-1];
    assign tx_next = r_q.tx[FRAME_BITS-2];
    assign rx_word = r_q.rx;

    AST_LOAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !(advance || cap_en)); // R5

endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl
    import adc_rd_pkg::*;
#(
    parameter int FRAME_BITS = 32,
    parameter int ADDR_BITS  = 5,
    parameter int DIV_W      = 8,
    parameter int POLL_LIMIT = 64,
    parameter int GAP_TICKS  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [ADDR_BITS-1:0]  mux_addr,
    input  logic                  abort_req,
    input  logic [DIV_W-1:0]      clk_div,
    input  logic                  spi_sdo,
    output logic                  spi_cs_n,
    output logic                  spi_sck,
    output logic                  spi_sdi,
    output logic [FRAME_BITS-1:0] result,
    output logic                  result_valid,
    output logic                  timeout_err
);

    localparam int BIT_W  = $clog2(FRAME_BITS + 1);
    localparam int POLL_W = $clog2(POLL_LIMIT + 1);
    localparam int GAP_W  = $clog2(GAP_TICKS + 1);

    typedef struct packed {
        rd_state_e             st;
        logic [GAP_W-1:0]      gap;
        logic [POLL_W-1:0]     poll;
        logic [BIT_W-1:0]      bits;
        logic                  cs_n;
        logic                  sck;
        logic                  sdi;
        logic                  valid;
        logic                  err;
        logic [FRAME_BITS-1:0] res;
    } ctrl_s;

    ctrl_s c_d, c_q;

    logic tick, load, advance, cap_en, tx_msb, tx_next;
    logic [FRAME_BITS-1:0] rx_word;

    rdc_tick_gen #(.DIV_W(DIV_W)) tick_i (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (c_q.st != ST_IDLE),
        .div  (clk_div),
        .tick (tick)
    );

    rdc_shifter #(.FRAME_BITS(FRAME_BITS), .ADDR_BITS(ADDR_BITS)) shift_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .addr   (mux_addr),
        .advance(advance),
        .cap_en (cap_en),
        .cap_bit(spi_sdo),
        .tx_msb (tx_msb),
        .tx_next(tx_next),
        .rx_word(rx_word)
    );

    always_comb begin
        c_d       = c_q;
        c_d.valid = 1'b0;
        load      = 1'b0;
        advance   = 1'b0;
        cap_en    = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    c_d.st  = ST_GAP;
                    c_d.gap = '0;
                    c_d.err = 1'b0;
                    load    = 1'b1;
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (c_q.gap == GAP_W'(GAP_TICKS - 1)) begin
                        c_d.st   = ST_POLL;
                        c_d.cs_n = 1'b0;
                        c_d.poll = '0;
                    end else begin
                        c_d.gap = c_q.gap + GAP_W'(1);
                    end
                end
            end
            ST_POLL: begin
                if (abort_req) begin
                    c_d.st   = ST_IDLE;
                    c_d.cs_n = 1'b1;
                end else if (tick) begin
                    if (!spi_sdo) begin
                        c_d.st   = ST_SHIFT;
                        c_d.bits = '0;
                        c_d.sdi  = tx_msb;
                    end else if (c_q.poll == POLL_W'(POLL_LIMIT - 1)) begin
                        c_d.st   = ST_IDLE;
                        c_d.cs_n = 1'b1;
                        c_d.err  = 1'b1;
                    end else begin
                        c_d.poll = c_q.poll + POLL_W'(1);
                    end
                end
            end
            ST_SHIFT: begin
                if (abort_req) begin
                    c_d.st   = ST_IDLE;
                    c_d.cs_n = 1'b1;
                    c_d.sck  = 1'b0;
                    c_d.sdi  = 1'b0;
                end else if (tick) begin
                    if (!c_q.sck) begin
                        c_d.sck  = 1'b1;
                        cap_en   = 1'b1;
                        c_d.bits = c_q.bits + BIT_W'(1);
                    end else begin
                        c_d.sck = 1'b0;
                        advance = 1'b1;
                        if (c_q.bits == BIT_W'(FRAME_BITS)) begin
                            c_d.st    = ST_IDLE;
                            c_d.cs_n  = 1'b1;
                            c_d.sdi   = 1'b0;
                            c_d.valid = 1'b1;
                            c_d.res   = rx_word;
                        end else begin
                            c_d.sdi = tx_next;
                        end
                    end
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q      <= '0;
            c_q.st   <= ST_IDLE;
            c_q.cs_n <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign spi_cs_n     = c_q.cs_n;
    assign spi_sck      = c_q.sck;
    assign spi_sdi      = c_q.sdi;
    assign result       = c_q.res;
    assign result_valid = c_q.valid;
    assign timeout_err  = c_q.err;

    AST_SCK_LOW_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck); // R3
    AST_SELECT_WITH_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> !spi_sck); // R3
    AST_SDI_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sdi); // R5
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid); // R6
    AST_STROBE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> spi_cs_n); // R6
    AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |=> (result_valid || $stable(result))); // R6
    AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_req && !spi_cs_n) |=> (spi_cs_n && !spi_sck && !result_valid)); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_err && !(c_q.st == ST_IDLE && start)) |=> timeout_err); // R8

endmodule

// File: tb/adc_readout_ctrl_tb_top.sv
module adc_readout_ctrl_tb_top;

    localparam int FB = 32;
    localparam int AB = 5;
    localparam int PL = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AB-1:0] mux_addr = '0;
    logic          abort_req = 1'b0;
    logic [7:0]    clk_div = 8'd2;
    logic          spi_sdo = 1'b1;
    logic          spi_cs_n, spi_sck, spi_sdi, result_valid, timeout_err;
    logic [FB-1:0] result;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    adc_readout_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mux_addr(mux_addr),
        .abort_req(abort_req), .clk_div(clk_div), .spi_sdo(spi_sdo),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_sdi(spi_sdi),
        .result(result), .result_valid(result_valid), .timeout_err(timeout_err)
    );

    task automatic check(string req, logic [FB-1:0] act, logic [FB-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // ---------------- behavioural converter -----------------
    logic [FB-1:0] adc_word = '0;
    logic [FB-1:0] adc_rx = '0;
    int adc_busy = 0;
    int adc_bit = 0;
    bit prev_sck = 0;

    always @(negedge clk) begin
        if (spi_cs_n) begin
            adc_bit  = 0;
            prev_sck = 0;
            spi_sdo  = 1'b1;
        end else begin
            if (adc_busy > 0) begin
                adc_busy--;
                spi_sdo = 1'b1;
            end else begin
                if (prev_sck && !spi_sck) adc_bit++;
                if (!prev_sck && spi_sck) adc_rx = {adc_rx[FB-2:0], spi_sdi};
                spi_sdo = (adc_bit < FB) ? adc_word[FB-1-adc_bit] : 1'b1;
            end
            prev_sck = spi_sck;
        end
    end

    // ---------------- reference model of the controller -----------------
    int  m_st = 0;          // 0 idle, 1 guard, 2 poll, 3 frame
    int  m_cnt = 0, m_ticks = 0, m_polls = 0, m_rises = 0;
    bit  m_tick;
    bit  e_cs_n = 1, e_sck = 0, e_sdi = 0, e_valid = 0, e_err = 0;
    logic [FB-1:0] e_res = '0, m_cap = '0;
    bit  m_cmd[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; e_cs_n = 1; e_sck = 0; e_sdi = 0;
            e_valid = 0; e_err = 0; e_res = '0; m_cmd.delete();
        end else begin
            m_tick  = (m_st != 0) && (m_cnt == int'(clk_div) - 1);
            m_cnt   = (m_st == 0 || m_tick) ? 0 : m_cnt + 1;
            e_valid = 0;
            case (m_st)
                0: if (start) begin
                    m_st = 1; m_ticks = 0; e_err = 0;
                    m_cmd.delete();
                    for (int i = FB - 1; i >= 0; i--)
                        m_cmd.push_back(i >= FB - AB ? mux_addr[i-(FB-AB)] : 1'b0);
                end
                1: if (m_tick) begin
                    m_ticks++;
                    if (m_ticks == 4) begin m_st = 2; e_cs_n = 0; m_polls = 0; end
                end
                2: if (abort_req) begin
                    m_st = 0; e_cs_n = 1;
                end else if (m_tick) begin
                    if (spi_sdo == 1'b0) begin
                        m_st = 3; m_rises = 0; e_sdi = m_cmd[0];
                    end else begin
                        m_polls++;
                        if (m_polls == PL) begin m_st = 0; e_cs_n = 1; e_err = 1; end
                    end
                end
                3: if (abort_req) begin
                    m_st = 0; e_cs_n = 1; e_sck = 0; e_sdi = 0;
                end else if (m_tick) begin
                    if (!e_sck) begin
                        e_sck = 1; m_rises++;
                        m_cap = {m_cap[FB-2:0], spi_sdo};
                    end else begin
                        e_sck = 0;
                        void'(m_cmd.pop_front());
                        if (m_rises == FB) begin
                            m_st = 0; e_cs_n = 1; e_sdi = 0; e_valid = 1; e_res = m_cap;
                        end else begin
                            e_sdi = m_cmd[0];
                        end
                    end
                end
                default: m_st = 0;
            endcase
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R2 select", spi_cs_n, e_cs_n);
            check("R9 serial clock", spi_sck, e_sck);
            check("R5 address line", spi_sdi, e_sdi);
            check("R6 strobe", result_valid, e_valid);
            check("R4 result word", result, e_res);
            check("R8 error flag", timeout_err, e_err);
            if (m_st == 2) check("R3 clock low while polling", spi_sck, 1'b0);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    bit seen_valid = 0;
    always @(negedge clk) if (result_valid) seen_valid = 1;

    task automatic pulse_start(logic [AB-1:0] a);
        @(negedge clk); mux_addr = a; start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic run_read(int div, logic [AB-1:0] a, logic [FB-1:0] w, int busy, bit poke);
        clk_div = 8'(div); adc_word = w; adc_busy = busy; adc_rx = '0;
        pulse_start(a);
        if (poke) begin
            while (spi_cs_n) @(negedge clk);
            repeat (2) @(negedge clk);
            mux_addr = ~a; start = 1'b1;   // must be ignored
            @(negedge clk); start = 1'b0;
        end
        for (int k = 0; k < 20000 && !result_valid; k++) @(negedge clk);
        check("R6 strobe seen", result_valid, 1'b1);
        check("R4 captured word", result, w);
        check("R5 address received", adc_rx, {a, {(FB-AB){1'b0}}});
        @(negedge clk);
        check("R6 strobe one cycle", result_valid, 1'b0);
        check("R6 result held", result, w);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 select", spi_cs_n, 1'b1);
        check("R1 clock", spi_sck, 1'b0);
        check("R1 data", spi_sdi, 1'b0);
        check("R1 strobe", result_valid, 1'b0);
        check("R1 error", timeout_err, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_read(2, 5'h13, 32'h0ABC_DE12, 20, 0);
        run_read(3, 5'h0C, 32'h2A5A_5A5A, 7, 1);
        run_read(1, 5'h1F, 32'h7FFF_0001, 0, 0);

        // R7: abort in the middle of a frame
        clk_div = 8'd1; adc_word = 32'h1234_5678; adc_busy = 3; seen_valid = 0;
        pulse_start(5'h01);
        while (!spi_sck) @(negedge clk);
        repeat (6) @(negedge clk);
        abort_req = 1'b1;
        @(negedge clk); abort_req = 1'b0;
        check("R7 select raised", spi_cs_n, 1'b1);
        check("R7 clock low", spi_sck, 1'b0);
        repeat (20) @(negedge clk);
        check("R7 no strobe", seen_valid, 1'b0);
        check("R7 result kept", result, 32'h7FFF_0001);

        // R8: status never ready
        clk_div = 8'd1; adc_busy = 1000000;
        pulse_start(5'h02);
        for (int k = 0; k < 5000 && !timeout_err; k++) @(negedge clk);
        check("R8 error set", timeout_err, 1'b1);
        check("R8 select raised", spi_cs_n, 1'b1);
        repeat (10) @(negedge clk);
        check("R8 error sticky", timeout_err, 1'b1);
        adc_busy = 0;
        pulse_start(5'h05);
        check("R8 error cleared by start", timeout_err, 1'b0);
        for (int k = 0; k < 20000 && !result_valid; k++) @(negedge clk);
        repeat (5) @(negedge clk);
        run_read(4, 5'h05, 32'h0000_FFFF, 2, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule